// File: doc/BRIEF.md
# Tagged Receive Character Queue

This block is the receive queue of a serial port with a fixed frame of eight data bits, no parity and one stop bit. A deserializer hands it one character at a time together with two per-character indications: the stop bit was bad (framing error), or the line was held low for a whole frame (break). The queue keeps 64 characters. Each entry stores the byte and its two indications side by side, so the indications stay with their character.

Software drains the queue through a read word. The low byte carries the data. The bits above it say whether the queue was empty, whether the character had a framing error and whether it was a break. A driver can therefore read until the empty bit appears, with no separate level check. A second word packs the receive occupancy together with a transmit occupancy supplied by the neighbouring transmit queue. When a character arrives while the queue is full, that character is discarded and a sticky overrun flag is raised. The flag stays up until the interrupt logic clears it.

Top module: `srx_tagfifo`

## Requirements
- R1: After reset, `rd_word` reads 0x100 (empty bit only), `level_word` bits 7:0 read 0 and `overrun` is 0.
- R2: Characters come out of `rd_word` bits 7:0 in the order they were written. The value appears in the cycle after the `rd_pop` edge.
- R3: A pop while the queue is empty returns 0x100: bit 8 set, data and tag bits zero. The occupancy and the read position do not change, so the next character written is the next one read.
- R4: Bit 9 of `rd_word` is the framing-error indication stored with that same character.
- R5: Bit 10 of `rd_word` is the break indication stored with that same character. Both tags may be set on one entry.
- R6: `level_word` bits 7:0 give the number of stored characters (0 to 64). Bits 15:8 repeat `tx_level` one cycle after it is presented.
- R7: The queue holds exactly 64 characters. A write while it holds 64 is discarded and leaves the stored contents and the occupancy unchanged.
- R8: A write while the queue is full sets `overrun`. It stays set until `ovr_clear` is pulsed. If a new overrun and a clear happen in the same cycle, the flag stays set.
- R9: A write and a pop in the same cycle on a non-empty queue both take effect, and the occupancy does not change.
- R10: `rd_word` holds its last value in cycles with no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a character is delivered |
| rx_byte | input | 8 | Received data byte |
| rx_ferr | input | 1 | Character had a bad stop bit |
| rx_brk | input | 1 | Character is a line break |
| rd_pop | input | 1 | Read-and-remove strobe for the read word |
| ovr_clear | input | 1 | Clears the sticky overrun flag |
| tx_level | input | 8 | Transmit queue occupancy from the transmit side |
| rd_word | output | 11 | {break, framing error, empty, data[7:0]} |
| level_word | output | 16 | {transmit occupancy, receive occupancy} |
| overrun | output | 1 | Sticky receive overrun flag |

## Verification
The in-line properties watch the cycle-level rules on every clock. They check that the occupancy never passes the depth, that a dropped write moves no pointer, that an empty pop moves nothing and yields the empty code, that a simultaneous write and pop leave the count unchanged, and that the overrun flag is set, held and cleared correctly. Data ordering, and whether the tags stay aligned with their characters across a full wrap of the storage, can only be shown by the directed scenarios, which compare every popped word against values the bench computed.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int BYTE_W   = 8;
  localparam int LVL_W    = 8;
  localparam int RDWORD_W = BYTE_W + 3;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic [BYTE_W-1:0] data;
  } rx_entry_t;

  // Read word layout: [10] break, [9] framing error, [8] empty, [7:0] data
  function automatic logic [RDWORD_W-1:0] pack_rd_word(rx_entry_t e, logic is_empty);
    if (is_empty) return {2'b00, 1'b1, {BYTE_W{1'b0}}};
    return {e.brk, e.ferr, 1'b0, e.data};
  endfunction
endpackage

// File: rtl/srx_tag_mem.sv
module srx_tag_mem
  import srx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  rx_entry_t     wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output rx_entry_t     rdata
);
  // Simple dual-port storage with a registered read port, block RAM style
  rx_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/srx_ptr_ctrl.sv
module srx_ptr_ctrl #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      waddr <= '0;
      raddr <= '0;
      count <= '0;
    end else begin
      if (wr_ok) waddr <= waddr + 1'b1;
      if (rd_ok) raddr <= raddr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  a_r7_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> ($stable(waddr) && $stable(count)));
  a_r3_empty_pop_still: assert property (@(posedge clk) disable iff (rst)
    (empty && pop) |=> $stable(raddr));
  a_r9_count_steady: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && rd_ok) |=> $stable(count));
endmodule

// File: rtl/srx_ovr_flag.sv
module srx_ovr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  a_r8_ovr_set: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  a_r8_ovr_cleared: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/srx_tagfifo.sv
module srx_tagfifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rx_valid,
  input  logic [BYTE_W-1:0]     rx_byte,
  input  logic                  rx_ferr,
  input  logic                  rx_brk,
  input  logic                  rd_pop,
  input  logic                  ovr_clear,
  input  logic [LVL_W-1:0]      tx_level,
  output logic [RDWORD_W-1:0]   rd_word,
  output logic [2*LVL_W-1:0]    level_word,
  output logic                  overrun
);
  logic          wr_ok, rd_ok, full, empty;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] count;
  rx_entry_t     wr_entry, head_q;
  logic          rd_was_empty_q;
  logic [LVL_W-1:0] tx_level_q, rx_field;

  assign wr_entry = '{brk: rx_brk, ferr: rx_ferr, data: rx_byte};

  srx_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push(rx_valid), .pop(rd_pop),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .waddr(waddr), .raddr(raddr),
    .count(count), .full(full), .empty(empty)
  );

  srx_tag_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(wr_ok), .waddr(waddr), .wdata(wr_entry),
    .re(rd_ok), .raddr(raddr), .rdata(head_q)
  );

  srx_ovr_flag u_ovr (
    .clk(clk), .rst(rst), .set(rx_valid && full), .clr(ovr_clear),
    .flag(overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_was_empty_q <= 1'b1;
      tx_level_q     <= '0;
    end else begin
      if (rd_pop) rd_was_empty_q <= empty;
      tx_level_q <= tx_level;
    end
  end

  assign rd_word = pack_rd_word(head_q, rd_was_empty_q);

  // Fit the occupancy count into its level field
  generate
    if (CW <= LVL_W) begin : g_lvl_fit
      assign rx_field = LVL_W'(count);
    end else begin : g_lvl_sat
      assign rx_field = (count > CW'({LVL_W{1'b1}})) ? {LVL_W{1'b1}} : count[LVL_W-1:0];
    end
  endgenerate

  assign level_word = {tx_level_q, rx_field};

  a_r3_empty_code: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && empty) |=> (rd_word == RDWORD_W'(11'h100)));
  a_r10_word_hold: assert property (@(posedge clk) disable iff (rst)
    (!rd_pop && !$past(rst)) |=> $stable(rd_word));
endmodule

// File: tb/srx_tagfifo_bench.sv
module srx_tagfifo_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ferr = 1'b0;
  logic        rx_brk = 1'b0;
  logic        rd_pop = 1'b0;
  logic        ovr_clear = 1'b0;
  logic [7:0]  tx_level = '0;
  logic [10:0] rd_word;
  logic [15:0] level_word;
  logic        overrun;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  srx_tagfifo u_srx_tagfifo (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rd_pop(rd_pop),
    .ovr_clear(ovr_clear), .tx_level(tx_level), .rd_word(rd_word),
    .level_word(level_word), .overrun(overrun)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO check FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic push(logic [7:0] b, logic fe, logic bk);
    rx_valid = 1'b1; rx_byte = b; rx_ferr = fe; rx_brk = bk;
    @(negedge clk);
    rx_valid = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic pop(output logic [10:0] w);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    w = rd_word;
  endtask

  function automatic logic [10:0] expect_word(logic [7:0] b, logic fe, logic bk);
    return {bk, fe, 1'b0, b};
  endfunction

  task automatic t_reset();
    chk("R1 read word", 32'(rd_word), 32'h100);
    chk("R1 rx level", 32'(level_word[7:0]), 0);
    chk("R1 overrun", 32'(overrun), 0);
  endtask

  task automatic t_order();
    logic [10:0] w;
    push(8'hA5, 0, 0); push(8'h3C, 0, 0); push(8'hF0, 0, 0);
    chk("R6 rx level three", 32'(level_word[7:0]), 3);
    pop(w); chk("R2 first", 32'(w), 32'h0A5);
    pop(w); chk("R2 second", 32'(w), 32'h03C);
    pop(w); chk("R2 third", 32'(w), 32'h0F0);
    chk("R6 rx level drained", 32'(level_word[7:0]), 0);
  endtask

  task automatic t_empty();
    logic [10:0] w;
    pop(w); chk("R3 empty code", 32'(w), 32'h100);
    chk("R3 level unchanged", 32'(level_word[7:0]), 0);
    push(8'h77, 0, 0);
    pop(w); chk("R3 next after empty", 32'(w), 32'h077);
  endtask

  task automatic t_tags();
    logic [10:0] w;
    push(8'h11, 1, 0); push(8'h22, 0, 1); push(8'h00, 1, 1); push(8'h33, 0, 0);
    pop(w); chk("R4 ferr tag", 32'(w), 32'(expect_word(8'h11, 1, 0)));
    pop(w); chk("R5 break tag", 32'(w), 32'(expect_word(8'h22, 0, 1)));
    pop(w); chk("R5 both tags", 32'(w), 32'(expect_word(8'h00, 1, 1)));
    pop(w); chk("R4 tag cleared", 32'(w), 32'(expect_word(8'h33, 0, 0)));
  endtask

  task automatic t_tx_level();
    tx_level = 8'h2A;
    chk("R6 tx field before edge", 32'(level_word[15:8]), 0);
    @(negedge clk);
    chk("R6 tx field", 32'(level_word[15:8]), 32'h2A);
    tx_level = 8'h05;
    @(negedge clk);
    chk("R6 tx field update", 32'(level_word[15:8]), 32'h05);
  endtask

  task automatic fill();
    for (int i = 0; i < 64; i++) push(8'(i * 3 + 1), i[0], i[1]);
  endtask

  task automatic drain(string req);
    logic [10:0] w;
    for (int i = 0; i < 64; i++) begin
      pop(w);
      chk(req, 32'(w), 32'(expect_word(8'(i * 3 + 1), i[0], i[1])));
    end
  endtask

  task automatic t_full();
    logic [10:0] w;
    fill();
    chk("R7 level full", 32'(level_word[7:0]), 64);
    chk("R8 no overrun yet", 32'(overrun), 0);
    push(8'hEE, 1, 1);
    chk("R7 level after drop", 32'(level_word[7:0]), 64);
    chk("R8 overrun set", 32'(overrun), 1);
    repeat (5) @(negedge clk);
    chk("R8 overrun sticky", 32'(overrun), 1);
    drain("R7 contents kept");
    pop(w); chk("R7 dropped byte absent", 32'(w), 32'h100);
    chk("R8 sticky after drain", 32'(overrun), 1);
    ovr_clear = 1'b1; @(negedge clk); ovr_clear = 1'b0;
    chk("R8 cleared", 32'(overrun), 0);
    fill();
    ovr_clear = 1'b1;
    push(8'h99, 0, 0);
    ovr_clear = 1'b0;
    chk("R8 set wins over clear", 32'(overrun), 1);
    drain("R7 second wrap");
    ovr_clear = 1'b1; @(negedge clk); ovr_clear = 1'b0;
    chk("R8 cleared again", 32'(overrun), 0);
  endtask

  task automatic t_simul();
    logic [10:0] w;
    push(8'h41, 0, 0); push(8'h42, 0, 0);
    rx_valid = 1'b1; rx_byte = 8'h43; rd_pop = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rd_pop = 1'b0;
    chk("R9 read in same cycle", 32'(rd_word), 32'h041);
    chk("R9 level steady", 32'(level_word[7:0]), 2);
    repeat (3) @(negedge clk);
    chk("R10 word held", 32'(rd_word), 32'h041);
    pop(w); chk("R9 second", 32'(w), 32'h042);
    pop(w); chk("R9 written byte", 32'(w), 32'h043);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order();
    t_empty();
    t_tags();
    t_tx_level();
    t_full();
    t_simul();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("Watchdog FAIL all: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule